// File: doc/BRIEF.md
# Row-Granular Locality Steering Table

This block decides, for every incoming update request, whether the work should go to a host-side cache path or to a compute unit that sits next to the memory. It keeps a small set-associative table. Each entry describes one whole DRAM row, not one cache line. A row that is touched again while it still holds an entry is treated as hot, and its requests go to the cache path. A row that is new to the table is treated as cold, and its request goes to the in-memory path.

Each entry holds three things: a row tag, a 3-bit saturating access counter, and a count of cache-path requests that have been issued but not yet completed. When a new row must take a slot in a full set, an older row is pushed out. If that older row still has cache-path work in flight, the block raises a one-cycle flush pulse that names the row, so that the work queued for it outside the block can be discarded. A hot working set larger than the table thrashes by design.

Each request is steered in a single cycle. Completions from the cache path arrive on a separate input.

Top module: `row_locality_steer`

## Requirements
- R1: While reset is held, and in the first cycle after it, every output is 0. No request can hit a table entry that existed before reset.
- R2: A request whose row holds no entry is routed to the compute path (`route_valid`=1, `route_cache`=0) with `alloc`=1. The new entry starts with a counter of 1 and a pending count of 0.
- R3: A request whose row holds an entry increments that entry's counter, saturating at 7. The request goes to the cache path (`route_cache`=1, `alloc`=0) when the counter after the increment is at least 2, and to the compute path otherwise.
- R4: On a miss, the slot to fill is chosen in this order: the invalid way with the lowest index if any way is invalid; otherwise the way with the lowest counter, with ties going to the lowest way index. Replacing a valid entry sets `evict_valid`=1, and `evict_row` carries the full row address of the displaced row.
- R5: Each cache-path route adds 1 to the pending count of its row, saturating at 15. A completion whose row is resident and has a nonzero count subtracts 1. A completion for a row that is not resident, or whose count is 0, changes nothing.
- R6: `flush_valid` pulses for one cycle only when the displaced row's pending count is nonzero, and `flush_row` then equals `evict_row`.
- R7: When a completion and a request arrive in the same cycle, the completion is applied first. The request's eviction and flush decisions see the decremented count.
- R8: The set index is the low 4 bits of the row address, and the sets are independent. Activity in one set never changes the routing or eviction behaviour of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | An update request is present |
| req_row | input | 16 | DRAM row address of the request |
| cpl_valid | input | 1 | A cache-path request has completed |
| cpl_row | input | 16 | Row of the completed request |
| route_valid | output | 1 | A routing decision is present |
| route_cache | output | 1 | 1 = cache path, 0 = compute path |
| alloc | output | 1 | The request allocated a new entry |
| evict_valid | output | 1 | The allocation displaced a valid entry |
| evict_row | output | 16 | Row address of the displaced entry |
| flush_valid | output | 1 | One-cycle pulse: discard pending cache work |
| flush_row | output | 16 | Row whose pending cache work must be discarded |

## Verification
Every output is registered. The decision for a request presented before a rising edge therefore appears right after that edge and stays for exactly one cycle. The bench drives inputs on the falling edge and updates its reference table at the same moment. It compares all seven outputs on the next falling edge, which is exactly one register stage after the stimulus. Completions take effect in that same edge, so their effect on pending counts is checked through the eviction or flush that a later request produces, never through internal state.

// File: rtl/row_locality_steer.sv
module row_locality_steer #(
  parameter int ROW_W  = 16,
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int CNT_W  = 3,
  parameter int PEND_W = 4,
  parameter int HOT_TH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [ROW_W-1:0] req_row,
  input  logic             cpl_valid,
  input  logic [ROW_W-1:0] cpl_row,
  output logic             route_valid,
  output logic             route_cache,
  output logic             alloc,
  output logic             evict_valid,
  output logic [ROW_W-1:0] evict_row,
  output logic             flush_valid,
  output logic [ROW_W-1:0] flush_row
);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ROW_W - IDX_W;
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  logic              vld  [SETS][WAYS];
  logic [TAG_W-1:0]  tag  [SETS][WAYS];
  logic [CNT_W-1:0]  cnt  [SETS][WAYS];
  logic [PEND_W-1:0] pend [SETS][WAYS];

  logic              n_vld  [SETS][WAYS];
  logic [TAG_W-1:0]  n_tag  [SETS][WAYS];
  logic [CNT_W-1:0]  n_cnt  [SETS][WAYS];
  logic [PEND_W-1:0] n_pend [SETS][WAYS];

  logic [IDX_W-1:0] rset, cset;
  logic [TAG_W-1:0] rtag, ctag;
  assign rset = req_row[IDX_W-1:0];
  assign rtag = req_row[ROW_W-1:IDX_W];
  assign cset = cpl_row[IDX_W-1:0];
  assign ctag = cpl_row[ROW_W-1:IDX_W];

  logic             hit, free_found;
  logic [WAY_W-1:0] hway, vic;
  logic [CNT_W-1:0] best, bumped;
  logic             d_route, d_cache, d_alloc, d_evict, d_flush;
  logic [ROW_W-1:0] d_erow;

  always_comb begin
    n_vld = vld; n_tag = tag; n_cnt = cnt; n_pend = pend;
    for (int w = 0; w < WAYS; w++)
      if (cpl_valid && vld[cset][w] && tag[cset][w] == ctag && pend[cset][w] != '0)
        n_pend[cset][w] = pend[cset][w] - 1'b1;

    hit = 1'b0; hway = '0;
    for (int w = 0; w < WAYS; w++)
      if (vld[rset][w] && tag[rset][w] == rtag) begin
        hit = 1'b1; hway = WAY_W'(w);
      end

    free_found = 1'b0; vic = '0;
    for (int w = 0; w < WAYS; w++)
      if (!vld[rset][w] && !free_found) begin
        free_found = 1'b1; vic = WAY_W'(w);
      end
    best = cnt[rset][0];
    if (!free_found)
      for (int w = 1; w < WAYS; w++)
        if (cnt[rset][w] < best) begin
          best = cnt[rset][w]; vic = WAY_W'(w);
        end

    bumped  = (cnt[rset][hway] == CNT_MAX) ? CNT_MAX : cnt[rset][hway] + 1'b1;
    d_route = req_valid;
    d_cache = 1'b0; d_alloc = 1'b0; d_evict = 1'b0; d_flush = 1'b0;
    d_erow  = {tag[rset][vic], rset};

    if (req_valid) begin
      if (hit) begin
        n_cnt[rset][hway] = bumped;
        if (bumped >= CNT_W'(HOT_TH)) begin
          d_cache = 1'b1;
          if (n_pend[rset][hway] != PEND_MAX)
            n_pend[rset][hway] = n_pend[rset][hway] + 1'b1;
        end
      end else begin
        d_alloc = 1'b1;
        d_evict = vld[rset][vic];
        d_flush = vld[rset][vic] && (n_pend[rset][vic] != '0);
        n_vld[rset][vic]  = 1'b1;
        n_tag[rset][vic]  = rtag;
        n_cnt[rset][vic]  = CNT_W'(1);
        n_pend[rset][vic] = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          vld[s][w]  <= 1'b0;
          tag[s][w]  <= '0;
          cnt[s][w]  <= '0;
          pend[s][w] <= '0;
        end
      route_valid <= 1'b0;
      route_cache <= 1'b0;
      alloc       <= 1'b0;
      evict_valid <= 1'b0;
      evict_row   <= '0;
      flush_valid <= 1'b0;
      flush_row   <= '0;
    end else begin
      vld  <= n_vld;
      tag  <= n_tag;
      cnt  <= n_cnt;
      pend <= n_pend;
      route_valid <= d_route;
      route_cache <= d_cache;
      alloc       <= d_alloc;
      evict_valid <= d_evict;
      evict_row   <= d_evict ? d_erow : '0;
      flush_valid <= d_flush;
      flush_row   <= d_flush ? d_erow : '0;
    end
  end
endmodule

// File: rtl/row_locality_steer_chk.sv
module row_locality_steer_chk #(
  parameter int ROW_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             route_valid,
  input logic             route_cache,
  input logic             alloc,
  input logic             evict_valid,
  input logic [ROW_W-1:0] evict_row,
  input logic             flush_valid,
  input logic [ROW_W-1:0] flush_row
);
  a_r1_route_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    route_valid |-> $past(req_valid));
  a_r2_alloc_goes_compute: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> route_valid && !route_cache);
  a_r3_cache_is_hit: assert property (@(posedge clk) disable iff (!rst_n)
    route_cache |-> route_valid && !alloc);
  a_r4_evict_needs_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |-> alloc);
  a_r6_flush_names_victim: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> evict_valid && flush_row == evict_row);
endmodule

bind row_locality_steer row_locality_steer_chk #(.ROW_W(ROW_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
  .route_valid(route_valid), .route_cache(route_cache), .alloc(alloc),
  .evict_valid(evict_valid), .evict_row(evict_row),
  .flush_valid(flush_valid), .flush_row(flush_row)
);

// File: tb/test_row_locality_steer.sv
module test_row_locality_steer;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, cpl_valid = 0;
  logic [15:0] req_row = 0, cpl_row = 0;
  logic route_valid, route_cache, alloc, evict_valid, flush_valid;
  logic [15:0] evict_row, flush_row;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  row_locality_steer i_row_locality_steer (
    .clk, .rst_n, .req_valid, .req_row, .cpl_valid, .cpl_row,
    .route_valid, .route_cache, .alloc, .evict_valid, .evict_row,
    .flush_valid, .flush_row);

  bit mv [16][4];
  int mt [16][4], mc [16][4], mp [16][4];
  bit e_rv, e_rc, e_al, e_ev, e_fl;
  logic [15:0] e_er, e_fr;

  function automatic int next_cnt(int c);
    return (c == 7) ? 7 : c + 1;
  endfunction

  task automatic model(bit rq, logic [15:0] row, bit cp, logic [15:0] crow);
    int s = row[3:0], t = row[15:4], cs = crow[3:0], ct = crow[15:4];
    int h = -1, v = -1;
    if (cp)
      for (int w = 0; w < 4; w++)
        if (mv[cs][w] && mt[cs][w] == ct && mp[cs][w] > 0) mp[cs][w]--;
    e_rv = rq; e_rc = 0; e_al = 0; e_ev = 0; e_fl = 0; e_er = 0; e_fr = 0;
    if (!rq) return;
    for (int w = 0; w < 4; w++) if (mv[s][w] && mt[s][w] == t) h = w;
    if (h >= 0) begin
      mc[s][h] = next_cnt(mc[s][h]);
      if (mc[s][h] >= 2) begin
        e_rc = 1;
        if (mp[s][h] < 15) mp[s][h]++;
      end
    end else begin
      for (int w = 3; w >= 0; w--) if (!mv[s][w]) v = w;
      if (v < 0) begin
        v = 0;
        for (int w = 1; w < 4; w++) if (mc[s][w] < mc[s][v]) v = w;
      end
      e_al = 1;
      if (mv[s][v]) begin
        e_ev = 1; e_er = {mt[s][v][11:0], row[3:0]};
        if (mp[s][v] > 0) begin e_fl = 1; e_fr = e_er; end
      end
      mv[s][v] = 1; mt[s][v] = t; mc[s][v] = 1; mp[s][v] = 0;
    end
  endtask

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit rq, logic [15:0] row, bit cp, logic [15:0] crow, string tag);
    req_valid = rq; req_row = row; cpl_valid = cp; cpl_row = crow;
    model(rq, row, cp, crow);
    @(negedge clk);
    req_valid = 0; cpl_valid = 0;
    chk({route_valid, route_cache, alloc, evict_valid, flush_valid} ==
        {e_rv, e_rc, e_al, e_ev, e_fl}, tag, "flags",
        {route_valid, route_cache, alloc, evict_valid, flush_valid},
        {e_rv, e_rc, e_al, e_ev, e_fl});
    if (e_ev) chk(evict_row == e_er, tag, "evict_row", evict_row, e_er);
    if (e_fl) chk(flush_row == e_fr, tag, "flush_row", flush_row, e_fr);
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 4; w++) begin mv[s][w] = 0; mt[s][w] = 0; mc[s][w] = 0; mp[s][w] = 0; end
    repeat (3) @(negedge clk);
    chk({route_valid, alloc, evict_valid, flush_valid} == 0, "R1", "reset outputs",
        {route_valid, alloc, evict_valid, flush_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    chk({route_valid, alloc, evict_valid, flush_valid} == 0, "R1", "after reset",
        {route_valid, alloc, evict_valid, flush_valid}, 0);

    step(1, 16'h0010, 0, 0, "R2");
    chk(alloc && !route_cache, "R2", "miss to compute", {alloc, route_cache}, 2'b10);
    step(1, 16'h0010, 0, 0, "R3");
    chk(route_cache, "R3", "second hit to cache", route_cache, 1);
    for (int i = 0; i < 8; i++) step(1, 16'h0010, 0, 0, "R3");
    step(1, 16'h0011, 0, 0, "R8");
    chk(alloc && !evict_valid, "R8", "other set independent", {alloc, evict_valid}, 2'b10);

    step(1, 16'h0020, 0, 0, "R4"); step(1, 16'h0030, 0, 0, "R4");
    step(1, 16'h0040, 0, 0, "R4");
    step(1, 16'h0030, 0, 0, "R4"); step(1, 16'h0030, 0, 0, "R4");
    step(1, 16'h0050, 0, 0, "R4");
    chk(evict_valid && evict_row == 16'h0020 && !flush_valid, "R4", "lowest count tie low way",
        evict_row, 16'h0020);

    step(1, 16'h1002, 0, 0, "R6"); step(1, 16'h1002, 0, 0, "R6");
    for (int k = 1; k <= 3; k++) for (int i = 0; i < 3; i++) step(1, 16'h1002 + 16'(k << 4) + 16'h0100, 0, 0, "R6");
    step(1, 16'h5002, 0, 0, "R6");
    chk(flush_valid && flush_row == 16'h1002, "R6", "flush on pending victim", flush_row, 16'h1002);
    step(0, 0, 0, 0, "R6");
    chk(!flush_valid, "R6", "flush is one cycle", flush_valid, 0);

    step(1, 16'h2003, 0, 0, "R5"); step(1, 16'h2003, 0, 0, "R5");
    for (int k = 1; k <= 3; k++) for (int i = 0; i < 3; i++) step(1, 16'h2003 + 16'(k << 4) + 16'h0100, 0, 0, "R5");
    step(0, 0, 1, 16'h7773, "R5");
    step(0, 0, 1, 16'h2003, "R5");
    step(0, 0, 1, 16'h2003, "R5");
    step(1, 16'h6003, 0, 0, "R5");
    chk(evict_valid && evict_row == 16'h2003 && !flush_valid, "R5", "drained row evicts clean",
        flush_valid, 0);

    step(1, 16'h3004, 0, 0, "R7"); step(1, 16'h3004, 0, 0, "R7");
    for (int k = 1; k <= 3; k++) for (int i = 0; i < 3; i++) step(1, 16'h3004 + 16'(k << 4) + 16'h0100, 0, 0, "R7");
    step(1, 16'h6004, 1, 16'h3004, "R7");
    chk(evict_valid && evict_row == 16'h3004 && !flush_valid, "R7", "completion first",
        flush_valid, 0);

    for (int i = 0; i < 3000; i++) begin
      logic [15:0] r, c;
      r = {8'h0, 4'($urandom % 6), 4'(8 + $urandom % 4)};
      c = {8'h0, 4'($urandom % 6), 4'(8 + $urandom % 4)};
      step($urandom % 4 != 0, r, $urandom % 3 == 0, c, "R3");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
  initial void'($urandom(32'd1234));
endmodule